// File: doc/BRIEF.md
# Receive Lane Polarity Detector

This block sits on one serial receive lane, after symbol alignment and before 8b/10b decoding. While link training is in progress it inspects the identifier field of each incoming training ordered set. That field is the ten symbols at indices 6 to 15. From it the block decides whether the lane's differential pair is wired swapped. A swapped pair arrives as the bitwise complement of every 10-bit symbol. Once the block has decided the pair is swapped, it complements every later received symbol before passing it on.

The decision belongs to the lane alone. Each lane of a link carries its own instance, so neighbouring lanes may settle on different polarities. Only received data is ever corrected. The first training ordered-set type carries the identifier D10.2, encoded as 10'h155. The second type carries D5.2, encoded as 10'h295. Either type can drive the decision. The external training controller supplies a training qualifier and a synchronous clear; it pulses the clear when the link retrains through its detect phase.

Top module: `rx_lane_polarity`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `inv_flag` is 0 and `sym_out_vld` is 0.
- R2: Each accepted symbol appears on `sym_out` exactly one clock after it was presented, and `sym_out_vld` repeats `sym_vld` delayed by one clock.
- R3: While `inv_flag` is 0, `sym_out` equals the delayed input symbol bit for bit.
- R4: A set is complete when, with `train_act` high, ten valid symbols arrive at indices 6,7,...,15 in order and each equals 10'h2AA, the complement of 10'h155. A complete set sets `inv_flag` in the clock that accepts index 15, so that symbol 15 is already emitted complemented.
- R5: A complete set whose ten identifier symbols each equal 10'h16A, the complement of 10'h295, sets `inv_flag` in the same way.
- R6: A complete set whose identifier symbols are all 10'h155, or all 10'h295, clears `inv_flag`.
- R7: A set is ignored and `inv_flag` keeps its value in any of these cases: any identifier symbol differs from the pattern chosen at index 6; the set mixes the two identifier types; or the set mixes normal and complemented symbols.
- R8: While `train_act` is low, no symbol takes part in detection and `inv_flag` holds. Dropping `train_act` in the middle of a set voids that set.
- R9: `clr` is synchronous. It forces `inv_flag` to 0 on the next clock and overrides a decision that completes in the same clock.
- R10: While `inv_flag` is 1, every output symbol is the bitwise complement of its input, both inside and outside training.
- R11: Identifier indices must be consecutive with no index skipped, or the set is void. Cycles with `sym_vld` low between symbols do not break a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous return to non-inverted, used on a full retrain |
| train_act | input | 1 | High while link training is in progress; enables detection |
| sym_vld | input | 1 | The lane presents a symbol this cycle |
| sym_idx | input | 4 | Position of the symbol within its ordered set |
| sym_in | input | 10 | Raw aligned 10-bit symbol |
| sym_out | output | 10 | Polarity-corrected symbol, one cycle late |
| sym_out_vld | output | 1 | Valid for `sym_out` |
| inv_flag | output | 1 | Latched polarity status, 1 when the pair is swapped |

## Verification
A wrong decision state shows first on `inv_flag` and on the last identifier symbol of the same set. Both are visible at the falling edge that follows acceptance of index 15. A wrong decision then corrupts every later symbol on `sym_out`, from the next cycle onward. A broken run tracker, such as one that misses a skipped index, a mixed set or a training drop, shows as a flag that changes when it should hold. The bench checks the flag after every set, so such a fault is seen within one ordered set.

// File: rtl/rx_lane_polarity.sv
module rx_lane_polarity #(
  parameter int W     = 10,
  parameter int IW    = 4,
  parameter int FIRST = 6,
  parameter int LAST  = 15,
  parameter logic [W-1:0] ID_A = 10'h155,
  parameter logic [W-1:0] ID_B = 10'h295
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          train_act,
  input  logic          sym_vld,
  input  logic [IW-1:0] sym_idx,
  input  logic [W-1:0]  sym_in,
  output logic [W-1:0]  sym_out,
  output logic          sym_out_vld,
  output logic          inv_flag
);

  localparam logic [IW-1:0] FIRST_I = IW'(FIRST);
  localparam logic [IW-1:0] LAST_I  = IW'(LAST);

  logic [W-1:0]  sym_q;
  logic          vld_q, inv_q;
  logic          armed_q, kind_b_q, norm_ok_q, cmpl_ok_q;
  logic [IW-1:0] last_idx_q;

  logic          take, at_first, in_run, kind_now, hit_norm, hit_cmpl;
  logic          norm_nx, cmpl_nx, finish;
  logic [W-1:0]  exp_id;

  assign take     = sym_vld & train_act;
  assign at_first = take && (sym_idx == FIRST_I);
  assign in_run   = take && armed_q && (sym_idx == IW'(last_idx_q + 1'b1))
                    && (sym_idx > FIRST_I) && (sym_idx <= LAST_I);
  assign kind_now = at_first ? ((sym_in == ID_B) || (sym_in == ~ID_B)) : kind_b_q;
  assign exp_id   = kind_now ? ID_B : ID_A;
  assign hit_norm = (sym_in == exp_id);
  assign hit_cmpl = (sym_in == ~exp_id);
  assign norm_nx  = at_first ? hit_norm : (norm_ok_q & hit_norm);
  assign cmpl_nx  = at_first ? hit_cmpl : (cmpl_ok_q & hit_cmpl);
  assign finish   = in_run && (sym_idx == LAST_I);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sym_q <= sym_in;
      vld_q <= sym_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      kind_b_q   <= 1'b0;
      norm_ok_q  <= 1'b0;
      cmpl_ok_q  <= 1'b0;
      last_idx_q <= '0;
    end else if (clr || !train_act) begin
      armed_q <= 1'b0;
    end else if (sym_vld) begin
      if (at_first || (in_run && !finish)) begin
        armed_q    <= 1'b1;
        kind_b_q   <= kind_now;
        norm_ok_q  <= norm_nx;
        cmpl_ok_q  <= cmpl_nx;
        last_idx_q <= sym_idx;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 inv_q <= 1'b0;
    else if (clr)               inv_q <= 1'b0;
    else if (finish && norm_nx) inv_q <= 1'b0;
    else if (finish && cmpl_nx) inv_q <= 1'b1;
  end

  assign sym_out     = sym_q ^ {W{inv_q}};
  assign sym_out_vld = vld_q;
  assign inv_flag    = inv_q;

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !inv_flag);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !train_act) |=> $stable(inv_flag));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (sym_out_vld == $past(sym_vld)));

  p_set_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_flag) |-> $past(sym_vld && train_act && (sym_idx == LAST_I) && !clr));

  p_drop_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inv_flag) |-> ($past(clr) || $past(sym_vld && train_act && (sym_idx == LAST_I))));

endmodule

// File: tb/rx_lane_polarity_tb.sv
module rx_lane_polarity_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       train_act = 1'b0;
  logic       sym_vld = 1'b0;
  logic [3:0] sym_idx = '0;
  logic [9:0] sym_in = '0;
  logic [9:0] sym_out;
  logic       sym_out_vld;
  logic       inv_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [9:0] vals [16];
  logic [3:0] idxs [16];
  bit         trn  [16];

  // fields: train, ts2, inverted, bad position (0 = none), expected flag after
  localparam logic [7:0] VEC [10] = '{
    {1'b1, 1'b0, 1'b1, 4'd0,  1'b1},
    {1'b1, 1'b0, 1'b0, 4'd0,  1'b0},
    {1'b1, 1'b1, 1'b1, 4'd0,  1'b1},
    {1'b1, 1'b0, 1'b0, 4'd9,  1'b1},
    {1'b0, 1'b0, 1'b0, 4'd0,  1'b1},
    {1'b1, 1'b1, 1'b0, 4'd0,  1'b0},
    {1'b1, 1'b1, 1'b1, 4'd15, 1'b0},
    {1'b1, 1'b0, 1'b1, 4'd6,  1'b0},
    {1'b1, 1'b0, 1'b1, 4'd0,  1'b1},
    {1'b1, 1'b1, 1'b0, 4'd12, 1'b1}
  };

  rx_lane_polarity u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .train_act(train_act),
    .sym_vld(sym_vld), .sym_idx(sym_idx), .sym_in(sym_in),
    .sym_out(sym_out), .sym_out_vld(sym_out_vld), .inv_flag(inv_flag)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FIAL_NOT %s", req);
    end
  endtask

  task automatic fill(input bit train, input bit ts2, input bit inv, input int bad);
    for (int i = 0; i < 16; i++) begin
      logic [9:0] id;
      id = ts2 ? 10'h295 : 10'h155;
      if (inv) id = ~id;
      vals[i] = (i < 6) ? 10'h0F0 + 10'(i) : id;
      if (bad != 0 && i == bad) vals[i] = vals[i] ^ 10'h001;
      idxs[i] = 4'(i);
      trn[i]  = train;
    end
  endtask

  task automatic play(input int n, input bit gaps, input bit clr_last,
                      input bit prev, input bit exp, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 7) chk({req, " sym6 out"}, sym_out, vals[6] ^ {10{prev}});
      sym_vld = 1'b1; sym_idx = idxs[i]; sym_in = vals[i]; train_act = trn[i];
      clr = clr_last && (i == n - 1);
      if (gaps) begin
        @(negedge clk);
        sym_vld = 1'b0;
      end
    end
    @(negedge clk);
    sym_vld = 1'b0; clr = 1'b0;
    if (!gaps) chk({req, " last out"}, sym_out, vals[n-1] ^ {10{exp}});
    chk({req, " flag"}, {9'd0, inv_flag}, {9'd0, exp});
  endtask

  task automatic chk_msg(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    bit model;
    model = 1'b0;
    @(negedge clk);
    chk_msg("R1 flag in reset", {9'd0, inv_flag}, 10'd0);
    chk_msg("R1 vld in reset", {9'd0, sym_out_vld}, 10'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_msg("R1 flag after reset", {9'd0, inv_flag}, 10'd0);
    chk_msg("R1 vld after reset", {9'd0, sym_out_vld}, 10'd0);

    // R2 R3 latency and passthrough
    sym_vld = 1'b1; sym_in = 10'h3C3; sym_idx = 4'd2;
    @(negedge clk);
    chk_msg("R2 vld delayed", {9'd0, sym_out_vld}, 10'd1);
    chk_msg("R3 passthrough", sym_out, 10'h3C3);
    sym_vld = 1'b0;
    @(negedge clk);
    chk_msg("R2 vld drop", {9'd0, sym_out_vld}, 10'd0);

    foreach (VEC[k]) begin
      logic [7:0] v;
      v = VEC[k];
      fill(v[7], v[6], v[5], int'(v[4:1]));
      play(16, 1'b0, 1'b0, model, v[0], $sformatf("R4/R5/R6/R7/R8 vec%0d", k));
      model = v[0];
    end

    // R7 mixed identifier types, complemented
    fill(1'b1, 1'b0, 1'b1, 0);
    for (int i = 11; i < 16; i++) vals[i] = 10'h16A;
    play(16, 1'b0, 1'b0, model, model, "R7 mixed types");

    // R8 training dropped mid-set
    fill(1'b1, 1'b0, 1'b0, 0);
    trn[10] = 1'b0;
    play(16, 1'b0, 1'b0, model, model, "R8 drop mid-set");

    // R11 skipped index (flag 1, normal set missing idx 10)
    fill(1'b1, 1'b0, 1'b0, 0);
    for (int i = 10; i < 15; i++) begin
      vals[i] = vals[i+1]; idxs[i] = idxs[i+1];
    end
    play(15, 1'b0, 1'b0, model, model, "R11 skipped idx");

    // R11 idle cycles inside a set
    fill(1'b1, 1'b0, 1'b0, 0);
    play(16, 1'b1, 1'b0, model, 1'b0, "R11 gaps normal");
    fill(1'b1, 1'b1, 1'b1, 0);
    play(16, 1'b1, 1'b0, 1'b0, 1'b1, "R11 gaps inverted");

    // R10 data outside training while inverted
    @(negedge clk);
    train_act = 1'b0; sym_vld = 1'b1; sym_in = 10'h3C3; sym_idx = 4'd1;
    @(negedge clk);
    sym_vld = 1'b0;
    chk_msg("R10 complement", sym_out, 10'h03C);

    // R9 clear
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk_msg("R9 clear", {9'd0, inv_flag}, 10'd0);
    fill(1'b1, 1'b0, 1'b1, 0);
    play(16, 1'b0, 1'b0, 1'b0, 1'b1, "R9 re-set");
    fill(1'b1, 1'b1, 1'b1, 0);
    play(16, 1'b0, 1'b1, 1'b1, 1'b0, "R9 clear beats decision");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule